// File: doc/BRIEF.md
# Residual-ISI Tap Balancer with Weighted Coefficient Integrator

This block sits between a bank of per-tap pattern decoders and one equalizer coefficient. Each decoder reports, now and then, a ternary estimate (+1, 0 or -1) of the residual inter-symbol interference at its own tap position. The balancer points at exactly one decoder at a time, chosen pseudo-randomly. It then waits, for as long as it takes, until that decoder produces a sample. The sample is multiplied by that tap's programmable signed weight and added into a saturating signed accumulator. The upper bits of the accumulator form the coefficient.

Each accepted sample draws a fresh random choice, so every tap is visited equally often on average. The adaptation dynamics therefore depend only on the weights, and the loop settles where the weighted sum of averaged residual ISI is zero. Samples that arrive from decoders not currently selected are discarded. A data stream that starves one decoder therefore stalls adaptation rather than biasing it. An enable input freezes the whole loop. A synchronous clear reloads a programmable starting coefficient.

Top module: `isi_tap_balancer`

## Requirements
- R1: After synchronous reset the coefficient output is 0 and the select output is 1, the two low bits of the generator seed 16'hACE1.
- R2: The selection comes from a 16-bit Fibonacci shift register. Each step it shifts left by one and inserts bit15^bit13^bit12^bit10 at bit 0. The select output equals state bits [1:0]. The register advances once per accepted sample and at no other time.
- R3: While the selected decoder has no valid sample, the block waits without any timeout. Valid samples on the other decoders are ignored: select and coefficient stay unchanged.
- R4: A sample is accepted when enable is high, clear is low and the selected decoder's valid is high. The accumulator then gains sample times that decoder's weight. The new coefficient and the new select both appear on the next clock cycle.
- R5: Sample encoding per decoder is up=1,dn=0 for +1 and up=0,dn=1 for -1. Both bits equal means 0. A zero sample is still accepted: it advances the selection but leaves the coefficient unchanged.
- R6: The accumulator never exceeds coef_max scaled by 2^FRAC_W. Updates that would go past that bound clamp to it instead of wrapping.
- R7: The accumulator never goes below coef_min scaled by 2^FRAC_W. Updates that would go past that bound clamp to it instead of wrapping.
- R8: With enable low and clear low, neither the select nor the coefficient changes, whatever the decoders present.
- R9: Clear loads init_coef as the coefficient, with a zero fraction, on the next cycle. Clear takes priority over a simultaneous sample, which is discarded without advancing the selection.
- R10: The weight for decoder i is a two's-complement field at bits [i*WGT_W +: WGT_W] of the weight bus. The weight is added at the least significant fractional bit of the accumulator.
- R11: The coefficient is the accumulator shifted right arithmetically by FRAC_W bits. Small weights therefore build up over several accepted samples before the coefficient moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Adaptation enable |
| clr | input | 1 | Synchronous reload of the initial coefficient |
| init_coef | input | COEF_W | Signed coefficient loaded by clr |
| coef_min | input | COEF_W | Signed lower coefficient limit |
| coef_max | input | COEF_W | Signed upper coefficient limit |
| tap_weights | input | NUM_DEC*WGT_W | Packed signed per-decoder weights |
| dec_valid | input | NUM_DEC | Sample-present flag per decoder |
| dec_up | input | NUM_DEC | Positive sample bit per decoder |
| dec_dn | input | NUM_DEC | Negative sample bit per decoder |
| sel | output | SEL_W | Index of the decoder currently watched |
| coef_out | output | COEF_W | Signed equalizer coefficient |

## Verification
The bench tracks the expected select sequence with its own model of the shift register. It checks that the design hands control to the next pseudo-random decoder only after the watched one delivers. A design that advanced on any decoder's valid, or that timed out, would fall out of step at once. Stray valids on unselected decoders are driven before every accepted sample; a design that accepted them would move the coefficient early. Long one-sided runs push the accumulator into both limits, where a wrapping adder would flip sign. The remaining checks cover clear arriving together with a valid sample, zero-valued samples, freezing with enable low, and small weights that only move the coefficient after the fraction overflows.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [1:0] {
    TS_ZERO = 2'b00,
    TS_POS  = 2'b01,
    TS_NEG  = 2'b10
  } tern_t;

  function automatic tern_t decode_tern(input logic up, input logic dn);
    if (up && !dn)      return TS_POS;
    else if (dn && !up) return TS_NEG;
    else                return TS_ZERO;
  endfunction
endpackage

// File: rtl/fpb_lfsr.sv
module fpb_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  logic fb;

  generate
    if (LFSR_W == 24) begin : g_taps24
      assign fb = state[23] ^ state[22] ^ state[21] ^ state[16];
    end else begin : g_taps16
      assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= {state[LFSR_W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R2
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state)); // R2
endmodule

// File: rtl/fpb_step_sel.sv
module fpb_step_sel
  import fpb_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int WGT_W   = 8,
  localparam int SEL_W  = $clog2(NUM_DEC)
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [NUM_DEC*WGT_W-1:0] weights,
  input  logic [NUM_DEC-1:0]       valid,
  input  logic [NUM_DEC-1:0]       up,
  input  logic [NUM_DEC-1:0]       dn,
  output logic                     hit,
  output logic signed [WGT_W:0]    step
);
  logic signed [WGT_W-1:0] wgt [NUM_DEC];
  tern_t                   smp [NUM_DEC];

  generate
    for (genvar i = 0; i < NUM_DEC; i++) begin : g_unpack
      assign wgt[i] = weights[i*WGT_W +: WGT_W];
      assign smp[i] = decode_tern(up[i], dn[i]);
    end
  endgenerate

  logic signed [WGT_W:0] wext;
  assign wext = {wgt[sel][WGT_W-1], wgt[sel]};
  assign hit  = valid[sel];

  always_comb begin
    unique case (smp[sel])
      TS_POS:  step = wext;
      TS_NEG:  step = -wext;
      default: step = '0;
    endcase
  end
endmodule

// File: rtl/fpb_sat_acc.sv
module fpb_sat_acc #(
  parameter int COEF_W = 8,
  parameter int FRAC_W = 4,
  parameter int STEP_W = 9,
  localparam int ACC_W = COEF_W + FRAC_W,
  localparam int SUM_W = ACC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     add_en,
  input  logic signed [STEP_W-1:0] step,
  input  logic signed [COEF_W-1:0] init_coef,
  input  logic signed [COEF_W-1:0] coef_min,
  input  logic signed [COEF_W-1:0] coef_max,
  output logic signed [COEF_W-1:0] coef
);
  logic signed [ACC_W-1:0] acc;
  logic signed [SUM_W-1:0] sum, lo, hi;

  assign lo  = {{2{coef_min[COEF_W-1]}}, coef_min, {FRAC_W{1'b0}}};
  assign hi  = {{2{coef_max[COEF_W-1]}}, coef_max, {FRAC_W{1'b0}}};
  assign sum = SUM_W'(acc) + SUM_W'(step);

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (clr)
      acc <= {init_coef, {FRAC_W{1'b0}}};
    else if (add_en) begin
      if (sum > hi)      acc <= hi[ACC_W-1:0];
      else if (sum < lo) acc <= lo[ACC_W-1:0];
      else               acc <= sum[ACC_W-1:0];
    end
  end

  assign coef = acc[ACC_W-1 -: COEF_W];

  AST_CLR_LOAD: assert property (@(posedge clk) disable iff (rst)
    clr |=> coef == $past(init_coef)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (add_en && !clr && coef_min <= coef_max) |=> coef <= $past(coef_max)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (add_en && !clr && coef_min <= coef_max) |=> coef >= $past(coef_min)); // R7
endmodule

// File: rtl/isi_tap_balancer.sv
module isi_tap_balancer #(
  parameter int NUM_DEC = 4,
  parameter int WGT_W   = 8,
  parameter int COEF_W  = 8,
  parameter int FRAC_W  = 4,
  parameter int LFSR_W  = 16,
  localparam int SEL_W  = $clog2(NUM_DEC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     clr,
  input  logic [COEF_W-1:0]        init_coef,
  input  logic [COEF_W-1:0]        coef_min,
  input  logic [COEF_W-1:0]        coef_max,
  input  logic [NUM_DEC*WGT_W-1:0] tap_weights,
  input  logic [NUM_DEC-1:0]       dec_valid,
  input  logic [NUM_DEC-1:0]       dec_up,
  input  logic [NUM_DEC-1:0]       dec_dn,
  output logic [SEL_W-1:0]         sel,
  output logic [COEF_W-1:0]        coef_out
);
  logic                  hit, accept;
  logic signed [WGT_W:0] step;
  logic [LFSR_W-1:0]     rng;

  assign accept = en && !clr && hit;

  fpb_lfsr #(.LFSR_W(LFSR_W)) u_rng (
    .clk(clk), .rst(rst), .adv(accept), .state(rng)
  );

  assign sel = rng[SEL_W-1:0];

  fpb_step_sel #(.NUM_DEC(NUM_DEC), .WGT_W(WGT_W)) u_pick (
    .sel(sel), .weights(tap_weights), .valid(dec_valid),
    .up(dec_up), .dn(dec_dn), .hit(hit), .step(step)
  );

  fpb_sat_acc #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .STEP_W(WGT_W+1)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .add_en(accept), .step(step),
    .init_coef(init_coef), .coef_min(coef_min), .coef_max(coef_max),
    .coef(coef_out)
  );

  AST_SEL_WAIT: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !dec_valid[sel]) |=> $stable(sel)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !dec_valid[sel]) |=> $stable(coef_out)); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> ($stable(coef_out) && $stable(sel))); // R8
  AST_CLR_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    clr |=> $stable(sel)); // R9
endmodule

// File: tb/isi_tap_balancer_bench.sv
module isi_tap_balancer_bench;
  localparam int N = 4, WW = 8, CW = 8, FW = 4;

  logic clk = 0, rst = 1, en = 0, clr = 0;
  logic [CW-1:0] init_coef = '0, coef_min = 8'sd100 * -1, coef_max = 8'd100;
  logic [N*WW-1:0] tap_weights = {8'd3, 8'd40, 8'hE8, 8'd16};
  logic [N-1:0] dec_valid = '0, dec_up = '0, dec_dn = '0;
  logic [1:0] sel;
  logic [CW-1:0] coef_out;

  always #10 clk = ~clk;

  isi_tap_balancer u_isi_tap_balancer (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .init_coef(init_coef),
    .coef_min(coef_min), .coef_max(coef_max), .tap_weights(tap_weights),
    .dec_valid(dec_valid), .dec_up(dec_up), .dec_dn(dec_dn),
    .sel(sel), .coef_out(coef_out)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int kv[4] = '{16, -24, 40, 3};
  int m_acc = 0, m_min = -100, m_max = 100;
  logic [15:0] m_lfsr = 16'hACE1;

  // sample codes: 1=+1, 2=-1, 0=zero (neither bit), 3=zero (both bits)
  localparam logic [1:0] VEC [16] = '{2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd3, 2'd2, 2'd2,
                                      2'd1, 2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd1};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_coef();
    return m_acc >>> FW;
  endfunction

  function automatic int sval(input logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? -1 : 0;
  endfunction

  task automatic model_accept(input int s);
    int hi, lo;
    hi = m_max * 16; lo = m_min * 16;
    m_acc = m_acc + s * kv[m_lfsr[1:0]];
    if (m_acc > hi) m_acc = hi;
    if (m_acc < lo) m_acc = lo;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  // drive one accepted sample on the watched decoder; inputs change at negedge
  task automatic send(input logic [1:0] code);
    logic [3:0] oh;
    oh = 4'b1 << m_lfsr[1:0];
    dec_valid = oh;
    dec_up = (code[0]) ? oh : 4'b0;
    dec_dn = (code[1]) ? oh : 4'b0;
    @(negedge clk);
    dec_valid = '0; dec_up = '0; dec_dn = '0;
    model_accept(sval(code));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    coef_min = 8'(-100);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 coef", $signed(coef_out), 0);
    check("R1 sel", sel, 1);
    en = 1;

    // table walk: stray valids first (R3), then the accepted sample (R2 R4 R5 R10 R11)
    for (int i = 0; i < 16; i++) begin
      logic [3:0] oh;
      oh = 4'b1 << m_lfsr[1:0];
      dec_valid = ~oh; dec_up = ~oh;
      @(negedge clk);
      dec_valid = '0; dec_up = '0;
      check("R3 sel held", sel, m_lfsr[1:0]);
      check("R3 coef held", $signed(coef_out), m_coef());
      send(VEC[i]);
      check("R2 sel sequence", sel, m_lfsr[1:0]);
      check("R4 R5 R10 R11 coef", $signed(coef_out), m_coef());
    end

    // freeze with enable low (R8)
    begin
      int c0, s0;
      c0 = m_coef(); s0 = m_lfsr[1:0];
      en = 0; dec_valid = '1; dec_up = '1;
      repeat (4) @(negedge clk);
      dec_valid = '0; dec_up = '0;
      check("R8 coef frozen", $signed(coef_out), c0);
      check("R8 sel frozen", sel, s0);
      en = 1;
    end

    // clear with simultaneous valid sample (R9)
    init_coef = 8'(-7); clr = 1;
    dec_valid = 4'b1 << m_lfsr[1:0]; dec_up = dec_valid;
    @(negedge clk);
    clr = 0; dec_valid = '0; dec_up = '0;
    m_acc = -7 * 16;
    check("R9 clear load", $signed(coef_out), -7);
    check("R9 no advance", sel, m_lfsr[1:0]);

    // upper saturation (R6)
    coef_max = 8'd3; m_max = 3;
    for (int i = 0; i < 40; i++) send((kv[m_lfsr[1:0]] > 0) ? 2'd1 : 2'd2);
    check("R6 clamp high", $signed(coef_out), 3);
    check("R6 model", $signed(coef_out), m_coef());

    // lower saturation (R7)
    coef_min = 8'(-3); m_min = -3;
    for (int i = 0; i < 40; i++) send((kv[m_lfsr[1:0]] > 0) ? 2'd2 : 2'd1);
    check("R7 clamp low", $signed(coef_out), -3);
    check("R7 sel", sel, m_lfsr[1:0]);

    // reset again returns to the initial state (R1)
    rst = 1; @(negedge clk); rst = 0;
    m_acc = 0; m_lfsr = 16'hACE1;
    check("R1 coef after reset", $signed(coef_out), 0);
    check("R1 sel after reset", sel, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule